// File: doc/BRIEF.md
# Model-Specific Register Bank

This block is a small bank of sparsely numbered configuration registers that a processor core reaches with a 32-bit register number and 64-bit data. The data travels as two 32-bit halves. The bank holds three registers. The first is a free-running 64-bit cycle counter that software may also load. The second holds the 4 KiB page number and enable bit of the local interrupt controller, together with a read-only flag that marks the boot processor. The third is the extended-feature register: it holds the fast system-call enable, the long-mode enable and the execute-disable enable, plus a long-mode-active status bit that the bank derives from the long-mode enable and an external paging-enable input.

Each access arrives on a valid/ready request channel and gets exactly one response on a valid/ready response channel. The bank accepts a request only when its response slot is empty or is being drained in that cycle (`req_ready = !rsp_valid || rsp_ready`). A response it has not handed over stays unchanged until `rsp_ready` is high. Numbered accesses require privilege level 0. A separate counter-read request bypasses the number decode and the privilege check, so that unprivileged code can sample the counter. A bad access returns zero data, changes no register and raises a fault.

The field values are also brought out as plain control pins, where the core's mode logic can use them.

Top module: `msr_bank`

## Requirements
- R1: The counter (number 0x10) reads 0 when a read is accepted on the first clock edge after reset is released. It then advances by exactly 1 on every clock edge, and it wraps from all-ones to 0.
- R2: A write to 0x10 loads the counter with `{req_wdata_hi, req_wdata_lo}`. The hi half is bits 63:32 and the lo half is bits 31:0. A read returns the counter in the same halves.
- R3: A counter load takes priority over the increment on that edge. A read accepted on the next edge returns exactly the loaded value, and counting continues from that value.
- R4: A numbered access (`req_ctr_only` = 0) made with `req_cpl` not equal to 0 faults. A faulting access leaves every register unchanged and returns zero data.
- R5: A request with `req_ctr_only` = 1 is a counter read. It is allowed at any privilege level, including 3, and it ignores `req_num`, `req_write` and the data halves.
- R6: Register 0x1B resets to page 0xFEE00 in bits 31:12, with the enable in bit 11 set to 1. A write sets bits 31:12 and bit 11 from `req_wdata_lo`. All other bits read as 0, including the whole hi half.
- R7: Bit 8 of register 0x1B always reads the `boot_cpu` pin. Writes to bit 8 have no effect.
- R8: Register 0xC0000080 resets to 0. Bit 0 is the system-call enable, bit 8 the long-mode enable and bit 11 the execute-disable enable; all three are written from `req_wdata_lo`. All other bits read as 0.
- R9: Bit 10 of 0xC0000080 reads 1 exactly when the long-mode enable is 1 and `paging_en` is 1. Writes to bit 10 have no effect.
- R10: An access to any other register number faults. A fault sets `rsp_fault` in its response, returns zero data, and raises `fault_pulse` for the single cycle after the request is accepted. A write that succeeds returns zero data.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and the response stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ctr_only | input | 1 | Unprivileged counter-read request |
| req_cpl | input | 2 | Privilege level of the requester |
| req_num | input | 32 | Register number |
| req_wdata_hi | input | 32 | Write data bits 63:32 |
| req_wdata_lo | input | 32 | Write data bits 31:0 |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken when high together with rsp_valid |
| rsp_rdata_hi | output | 32 | Read data bits 63:32 |
| rsp_rdata_lo | output | 32 | Read data bits 31:0 |
| rsp_fault | output | 1 | Response belongs to a faulting access |
| fault_pulse | output | 1 | One-cycle fault strobe |
| boot_cpu | input | 1 | Static boot-processor strap |
| paging_en | input | 1 | Paging turned on by the core |
| lapic_page | output | 20 | Interrupt controller page number |
| lapic_en | output | 1 | Interrupt controller enable |
| sce_en | output | 1 | System-call enable |
| lme_en | output | 1 | Long-mode enable |
| lma_act | output | 1 | Long mode active |
| nxe_en | output | 1 | Execute-disable enable |

## Verification
A sweep covers every privilege level, each implemented number and two unimplemented neighbours, and both reads and writes. It separates faults caused by privilege from faults caused by decode, and it shows that a rejected write leaves the stored fields unchanged. Back-to-back counter reads and loads near the all-ones value tell a correct load-then-count order from an off-by-one, and they expose any carry bug between the two halves. Toggling the boot strap and the paging input, while writes try the read-only bits, shows that those bits follow only the pins and the long-mode enable. A held response with `rsp_ready` low shows that back-pressure stalls new requests instead of dropping them.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int NUM_W = 32;
  localparam logic [NUM_W-1:0] NUM_CTR   = 32'h0000_0010;
  localparam logic [NUM_W-1:0] NUM_LAPIC = 32'h0000_001B;
  localparam logic [NUM_W-1:0] NUM_EFER  = 32'hC000_0080;

  // field positions inside the low half
  localparam int LAPIC_EN_BIT   = 11;
  localparam int LAPIC_BOOT_BIT = 8;
  localparam int LAPIC_PAGE_LSB = 12;
  localparam int EFER_SCE_BIT   = 0;
  localparam int EFER_LME_BIT   = 8;
  localparam int EFER_LMA_BIT   = 10;
  localparam int EFER_NXE_BIT   = 11;

  typedef enum logic [1:0] {SEL_NONE, SEL_CTR, SEL_LAPIC, SEL_EFER} reg_sel_e;

  function automatic reg_sel_e decode_num(input logic [NUM_W-1:0] num);
    case (num)
      NUM_CTR:   return SEL_CTR;
      NUM_LAPIC: return SEL_LAPIC;
      NUM_EFER:  return SEL_EFER;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/msr_cycle_ctr.sv
module msr_cycle_ctr #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)  cnt_o <= '0;
    else if (ld) cnt_o <= ld_val;
    else         cnt_o <= cnt_o + W'(1);
  end

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ld)) |-> cnt_o == $past(cnt_o) + W'(1));

  assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ld)) |-> cnt_o == $past(ld_val));
endmodule

// File: rtl/msr_lapic_reg.sv
module msr_lapic_reg #(
  parameter int          HALF_W   = 32,
  parameter int          PAGE_W   = HALF_W - 12,
  parameter logic [PAGE_W-1:0] PAGE_RST = 20'hFEE00,
  parameter logic        EN_RST   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic              wr_en_bit,
  input  logic              boot_cpu,
  output logic [HALF_W-1:0] rd_data,
  output logic [PAGE_W-1:0] page_o,
  output logic              en_o
);
  import msr_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_o <= PAGE_RST;
      en_o   <= EN_RST;
    end else if (wr) begin
      page_o <= wr_page;
      en_o   <= wr_en_bit;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[LAPIC_PAGE_LSB +: PAGE_W] = page_o;
    rd_data[LAPIC_EN_BIT]             = en_o;
    rd_data[LAPIC_BOOT_BIT]           = boot_cpu;
  end
endmodule

// File: rtl/msr_efer_reg.sv
module msr_efer_reg #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              wr_sce,
  input  logic              wr_lme,
  input  logic              wr_nxe,
  input  logic              paging_en,
  output logic [HALF_W-1:0] rd_data,
  output logic              sce_o,
  output logic              lme_o,
  output logic              lma_o,
  output logic              nxe_o
);
  import msr_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sce_o <= 1'b0;
      lme_o <= 1'b0;
      nxe_o <= 1'b0;
    end else if (wr) begin
      sce_o <= wr_sce;
      lme_o <= wr_lme;
      nxe_o <= wr_nxe;
    end
  end

  // long mode is live only once paging is on as well
  assign lma_o = lme_o & paging_en;

  always_comb begin
    rd_data = '0;
    rd_data[EFER_SCE_BIT] = sce_o;
    rd_data[EFER_LME_BIT] = lme_o;
    rd_data[EFER_LMA_BIT] = lma_o;
    rd_data[EFER_NXE_BIT] = nxe_o;
  end
endmodule

// File: rtl/msr_bank.sv
module msr_bank #(
  parameter int          HALF_W        = 32,
  parameter logic [19:0] LAPIC_PAGE_RST = 20'hFEE00,
  parameter logic        LAPIC_EN_RST   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_ctr_only,
  input  logic [1:0]        req_cpl,
  input  logic [31:0]       req_num,
  input  logic [HALF_W-1:0] req_wdata_hi,
  input  logic [HALF_W-1:0] req_wdata_lo,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [HALF_W-1:0] rsp_rdata_hi,
  output logic [HALF_W-1:0] rsp_rdata_lo,
  output logic              rsp_fault,
  output logic              fault_pulse,
  input  logic              boot_cpu,
  input  logic              paging_en,
  output logic [19:0]       lapic_page,
  output logic              lapic_en,
  output logic              sce_en,
  output logic              lme_en,
  output logic              lma_act,
  output logic              nxe_en
);
  import msr_pkg::*;

  localparam int CNT_W  = 2 * HALF_W;
  localparam int PAGE_W = HALF_W - LAPIC_PAGE_LSB;

  logic             accept, bad, do_wr;
  reg_sel_e         num_sel, eff_sel;
  logic [CNT_W-1:0] ctr_val, rd_mux;
  logic [HALF_W-1:0] lapic_rd, efer_rd;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign num_sel   = decode_num(req_num);
  assign eff_sel   = req_ctr_only ? SEL_CTR : num_sel;
  assign bad       = !req_ctr_only && (num_sel == SEL_NONE || req_cpl != 2'd0);
  assign do_wr     = accept && req_write && !req_ctr_only && !bad;

  msr_cycle_ctr #(.W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .ld(do_wr && eff_sel == SEL_CTR),
    .ld_val({req_wdata_hi, req_wdata_lo}),
    .cnt_o(ctr_val)
  );

  msr_lapic_reg #(
    .HALF_W(HALF_W), .PAGE_W(PAGE_W),
    .PAGE_RST(PAGE_W'(LAPIC_PAGE_RST)), .EN_RST(LAPIC_EN_RST)
  ) u_lapic (
    .clk(clk), .rst_n(rst_n),
    .wr(do_wr && eff_sel == SEL_LAPIC),
    .wr_page(req_wdata_lo[LAPIC_PAGE_LSB +: PAGE_W]),
    .wr_en_bit(req_wdata_lo[LAPIC_EN_BIT]),
    .boot_cpu(boot_cpu),
    .rd_data(lapic_rd),
    .page_o(lapic_page),
    .en_o(lapic_en)
  );

  msr_efer_reg #(.HALF_W(HALF_W)) u_efer (
    .clk(clk), .rst_n(rst_n),
    .wr(do_wr && eff_sel == SEL_EFER),
    .wr_sce(req_wdata_lo[EFER_SCE_BIT]),
    .wr_lme(req_wdata_lo[EFER_LME_BIT]),
    .wr_nxe(req_wdata_lo[EFER_NXE_BIT]),
    .paging_en(paging_en),
    .rd_data(efer_rd),
    .sce_o(sce_en), .lme_o(lme_en), .lma_o(lma_act), .nxe_o(nxe_en)
  );

  always_comb begin
    case (eff_sel)
      SEL_CTR:   rd_mux = ctr_val;
      SEL_LAPIC: rd_mux = {{HALF_W{1'b0}}, lapic_rd};
      SEL_EFER:  rd_mux = {{HALF_W{1'b0}}, efer_rd};
      default:   rd_mux = '0;
    endcase
    if (bad || (req_write && !req_ctr_only)) rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_rdata_hi <= '0;
      rsp_rdata_lo <= '0;
      rsp_fault    <= 1'b0;
      fault_pulse  <= 1'b0;
    end else begin
      fault_pulse <= accept && bad;
      if (accept) begin
        rsp_valid    <= 1'b1;
        rsp_rdata_hi <= rd_mux[CNT_W-1:HALF_W];
        rsp_rdata_lo <= rd_mux[HALF_W-1:0];
        rsp_fault    <= bad;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assert_fault_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bad) |=> ($stable(lapic_page) && $stable(lapic_en) && $stable(sce_en)
                         && $stable(lme_en) && $stable(nxe_en)));

  assert_fault_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> (rsp_fault && rsp_valid && rsp_rdata_hi == '0 && rsp_rdata_lo == '0));

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata_hi)
                                   && $stable(rsp_rdata_lo) && $stable(rsp_fault)));
endmodule

// File: tb/msr_bank_test.sv
`timescale 1ns/1ps
module msr_bank_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, req_valid, req_ready, req_write, req_ctr_only;
  logic [1:0]  req_cpl;
  logic [31:0] req_num, req_wdata_hi, req_wdata_lo;
  logic        rsp_valid, rsp_ready, rsp_fault, fault_pulse, boot_cpu, paging_en;
  logic [31:0] rsp_rdata_hi, rsp_rdata_lo;
  logic [19:0] lapic_page;
  logic        lapic_en, sce_en, lme_en, lma_act, nxe_en;

  msr_bank uut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [63:0] got;
  logic        got_fault, got_pulse, got_valid;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a negedge, accepted at the next posedge, sampled at the following negedge
  task automatic do_req(input bit wr, input bit ctr, input logic [1:0] cpl,
                        input logic [31:0] num, input logic [31:0] hi, input logic [31:0] lo);
    req_valid = 1; req_write = wr; req_ctr_only = ctr; req_cpl = cpl;
    req_num = num; req_wdata_hi = hi; req_wdata_lo = lo;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    got = {rsp_rdata_hi, rsp_rdata_lo};
    got_fault = rsp_fault; got_pulse = fault_pulse; got_valid = rsp_valid;
  endtask

  function automatic logic [63:0] lapic_val(input logic [19:0] pg, input bit en, input bit bsp);
    return 64'({pg, 12'h0}) | (64'(en) << 11) | (64'(bsp) << 8);
  endfunction
  function automatic logic [63:0] efer_val(input bit nxe, input bit lma, input bit lme, input bit sce);
    return (64'(nxe) << 11) | (64'(lma) << 10) | (64'(lme) << 8) | 64'(sce);
  endfunction
  function automatic logic [31:0] num_of(input int k);
    case (k)
      0: return 32'h10;
      1: return 32'h1B;
      2: return 32'hC000_0080;
      3: return 32'h11;
      default: return 32'hC000_0081;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] prev;
    logic [19:0] m_pg; bit m_en, m_sce, m_lme, m_nxe;
    rst_n = 0; req_valid = 0; req_write = 0; req_ctr_only = 0; req_cpl = 0;
    req_num = 0; req_wdata_hi = 0; req_wdata_lo = 0; rsp_ready = 1;
    boot_cpu = 1; paging_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset value and step
    do_req(0, 0, 0, 32'h10, 0, 0);
    check(got == 0 && !got_fault, "R1 counter after reset", got, 0);
    prev = got;
    do_req(0, 0, 0, 32'h10, 0, 0);
    check(got == prev + 1, "R1 counter step", got, prev + 1);

    // R6/R8: reset values
    do_req(0, 0, 0, 32'h1B, 0, 0);
    check(got == lapic_val(20'hFEE00, 1, 1), "R6 lapic reset", got, lapic_val(20'hFEE00, 1, 1));
    do_req(0, 0, 0, 32'hC000_0080, 0, 0);
    check(got == 0, "R8 efer reset", got, 0);

    // R2/R3: load, halves, priority over count, wrap (R1)
    do_req(1, 0, 0, 32'h10, 32'h1234_5678, 32'h9ABC_DEF0);
    check(got == 0 && !got_fault, "R10 write returns zero", got, 0);
    do_req(0, 0, 0, 32'h10, 0, 0);
    check(got == 64'h1234_5678_9ABC_DEF0, "R2 R3 counter load halves", got, 64'h1234_5678_9ABC_DEF0);
    do_req(1, 0, 0, 32'h10, 32'hFFFF_FFFF, 32'hFFFF_FFFE);
    do_req(0, 0, 0, 32'h10, 0, 0);
    check(got == 64'hFFFF_FFFF_FFFF_FFFE, "R3 load wins", got, 64'hFFFF_FFFF_FFFF_FFFE);
    do_req(0, 0, 0, 32'h10, 0, 0);
    check(got == 64'hFFFF_FFFF_FFFF_FFFF, "R3 count resumes", got, 64'hFFFF_FFFF_FFFF_FFFF);
    do_req(0, 0, 0, 32'h10, 0, 0);
    check(got == 0, "R1 counter wrap", got, 0);
    do_req(1, 0, 0, 32'h10, 32'h0000_0000, 32'hFFFF_FFFF);
    do_req(0, 0, 0, 32'h10, 0, 0);
    do_req(0, 0, 0, 32'h10, 0, 0);
    check(got == 64'h1_0000_0000, "R1 carry into hi half", got, 64'h1_0000_0000);

    // R5: unprivileged counter read, number/write ignored
    do_req(1, 0, 0, 32'h10, 32'h0000_00AB, 32'h0000_0100);
    do_req(1, 1, 3, 32'h1B, 32'hDEAD_BEEF, 32'h0);
    check(got == 64'hAB_0000_0100 && !got_fault, "R5 cpl3 counter read", got, 64'hAB_0000_0100);
    do_req(0, 0, 0, 32'h1B, 0, 0);
    check(got == lapic_val(20'hFEE00, 1, 1), "R5 counter read left lapic alone", got, lapic_val(20'hFEE00, 1, 1));

    // R4/R6/R8/R10: sweep of privilege x number x direction
    m_pg = 20'hFEE00; m_en = 1; m_sce = 0; m_lme = 0; m_nxe = 0;
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 5; k++)
        for (int w = 0; w < 2; w++) begin
          logic [31:0] lo;
          bit exp_bad;
          logic [63:0] exp;
          lo = 32'h5A5A_A5A5 ^ (32'h0101_0111 * (c * 10 + k * 2 + 1)) ^ {20'h0, 1'b0, 11'h0};
          exp_bad = (k > 2) || (c != 0);
          if (w == 0) do_req(1, 0, 2'(c), num_of(k), 32'hFFFF_FFFF, lo);
          else        do_req(0, 0, 2'(c), num_of(k), 0, 0);
          check(got_fault == exp_bad && got_pulse == exp_bad && got_valid,
                exp_bad ? "R4 R10 fault flag" : "R4 no fault", 64'(got_fault), 64'(exp_bad));
          if (w == 0 || exp_bad) exp = 0;
          else if (k == 1) exp = lapic_val(m_pg, m_en, 1);
          else if (k == 2) exp = efer_val(m_nxe, 0, m_lme, m_sce);
          else exp = got;
          check(got == exp, exp_bad ? "R10 fault data zero" : "R6 R8 readback", got, exp);
          if (w == 0 && !exp_bad && k == 1) begin m_pg = lo[31:12]; m_en = lo[11]; end
          if (w == 0 && !exp_bad && k == 2) begin m_sce = lo[0]; m_lme = lo[8]; m_nxe = lo[11]; end
        end
    @(negedge clk);
    check(fault_pulse == 0, "R10 fault pulse one cycle", 64'(fault_pulse), 0);
    do_req(0, 0, 0, 32'h1B, 0, 0);
    check(got == lapic_val(m_pg, m_en, 1), "R4 lapic unchanged after faults", got, lapic_val(m_pg, m_en, 1));

    // R7: boot flag read-only
    do_req(1, 0, 0, 32'h1B, 0, 32'h0012_3800);
    do_req(0, 0, 0, 32'h1B, 0, 0);
    check(got == lapic_val(20'h00123, 1, 1), "R7 boot bit stays 1 after write 0", got, lapic_val(20'h00123, 1, 1));
    boot_cpu = 0;
    do_req(1, 0, 0, 32'h1B, 0, 32'hFFFF_F7FF);
    do_req(0, 0, 0, 32'h1B, 0, 0);
    check(got == lapic_val(20'hFFFFF, 0, 0), "R7 boot bit follows pin", got, lapic_val(20'hFFFFF, 0, 0));

    // R9: long-mode active
    paging_en = 1;
    do_req(1, 0, 0, 32'hC000_0080, 0, 32'h0000_0100);
    do_req(0, 0, 0, 32'hC000_0080, 0, 0);
    check(got == efer_val(0, 1, 1, 0), "R9 active with lme and paging", got, efer_val(0, 1, 1, 0));
    do_req(1, 0, 0, 32'hC000_0080, 0, 32'h0000_0C01);
    do_req(0, 0, 0, 32'hC000_0080, 0, 0);
    check(got == efer_val(1, 0, 0, 1), "R9 bit10 write ignored", got, efer_val(1, 0, 0, 1));
    paging_en = 0;
    do_req(1, 0, 0, 32'hC000_0080, 0, 32'hFFFF_FFFF);
    do_req(0, 0, 0, 32'hC000_0080, 0, 0);
    check(got == efer_val(1, 0, 1, 1), "R9 inactive without paging", got, efer_val(1, 0, 1, 1));

    // R11: back-pressure
    rsp_ready = 0;
    do_req(0, 0, 0, 32'h1B, 0, 0);
    prev = got;
    req_valid = 1; req_write = 0; req_ctr_only = 0; req_cpl = 0; req_num = 32'hC000_0080;
    check(req_ready == 0, "R11 stall while held", 64'(req_ready), 0);
    @(posedge clk); @(negedge clk);
    check(rsp_valid && {rsp_rdata_hi, rsp_rdata_lo} == prev, "R11 response held", {rsp_rdata_hi, rsp_rdata_lo}, prev);
    rsp_ready = 1;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    check({rsp_rdata_hi, rsp_rdata_lo} == efer_val(1, 0, 1, 1), "R11 stalled request served",
          {rsp_rdata_hi, rsp_rdata_lo}, efer_val(1, 0, 1, 1));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule